// File: doc/BRIEF.md
# Serial Link PRBS Self-Test Engine

This block runs an at-speed interconnect test across a word-serial link. Its transmit half emits a fixed-length stream of pseudo-random words when told to start. Its receive half is armed by a test-control command. It waits for the far end's stream to appear, locks onto that stream from the data itself, and counts every bit that disagrees with the locally regenerated sequence. At the end of the run it reports a two-bit status: test complete, and pass/fail.

The two halves are independent, so the receive half can check a stream from a remote transmitter. Both are normally started by one test command. The checker enforces a start window: the first received word must appear within a bounded number of system clocks after arming, or the test ends at once as a failure. A word cycle with no valid strobe during the run is treated as a full word of bit errors, so a link that drops lock cannot pass. Because the checker seeds itself from the received bits, it tolerates any loopback latency.

Top module: `link_selftest`

## Requirements
- R1: After a synchronous reset, `done_o`, `pass_o` and `tx_valid_o` are low.
- R2: A cycle with `tx_start_i` high (re)starts the generator. `tx_valid_o` is low in the following cycle. From the next cycle on, exactly RUN_WORDS consecutive valid words follow. The stream obeys b(n) = b(n-14) xor b(n-15), which is the x^15+x^14+1 sequence. Bit 0 of each word is the earliest bit.
- R3: A cycle with `arm_i` high clears `done_o` and `pass_o` in the next cycle and restarts the checker from any state, including the middle of a run.
- R4: After the arm cycle, the checker samples `rx_valid_i` on each of the next START_WIN clock edges. If none of them sees it high, `done_o` rises with `pass_o` low after the START_WIN-th of those edges.
- R5: The first valid word inside the window starts a run of exactly RUN_WORDS word cycles, counting that word. `done_o` rises after the edge that samples the last of these cycles.
- R6: The first two words of a run seed the checker's reference and are not checked. Bits 0 to WORD_W-6 of the first word do not enter the seed and have no effect on the result.
- R7: From the third word on, each bit that differs from the regenerated sequence counts as one error. `pass_o` is set if and only if the error total is at most floor(RUN_WORDS*WORD_W/BER_DEN). This includes errors in the last word of the run.
- R8: A run cycle with `rx_valid_i` low adds WORD_W errors. The reference still advances one word in that cycle.
- R9: `done_o` and `pass_o` hold their values until the next arm cycle. `pass_o` is high only while `done_o` is high.
- R10: The result does not depend on the latency between the generator output and the checker input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_start_i | input | 1 | One-cycle pulse that starts the pattern stream |
| tx_word_o | output | WORD_W | Generated pattern word |
| tx_valid_o | output | 1 | Generated word is valid |
| arm_i | input | 1 | One-cycle pulse that arms the checker |
| rx_word_i | input | WORD_W | Received word from the link |
| rx_valid_i | input | 1 | Received word is valid (link locked) |
| done_o | output | 1 | Test complete status bit |
| pass_o | output | 1 | Pass status bit, meaningful while done_o is high |

## Verification
The bench builds the block with WORD_W=10, RUN_WORDS=400, BER_DEN=1000 and START_WIN=16. That puts the error threshold at four bits and a full run at a few hundred cycles. With these values the exact threshold edge (four errors pass, five fail), a dropped word, the last-word count and both sides of the start window can all be reached in a short run. A two-cycle loopback delay sits between generator and checker, so the self-seeding path is exercised under nonzero latency.

// File: rtl/lst_pkg.sv
package lst_pkg;

  localparam int PRBS_LEN = 15;

  typedef logic [PRBS_LEN-1:0] prbs_state_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_RUN  = 2'd2
  } chk_state_t;

  // Bit k of the result is the k-th generated bit; state bit 0 is newest.
  function automatic logic [31:0] prbs_bits(prbs_state_t h, int n);
    logic [31:0] r;
    prbs_state_t s;
    r = '0;
    s = h;
    for (int k = 0; k < 32; k++) begin
      if (k < n) begin
        r[k] = s[13] ^ s[14];
        s    = {s[13:0], r[k]};
      end
    end
    return r;
  endfunction

  function automatic prbs_state_t prbs_after(prbs_state_t h, int n);
    prbs_state_t s;
    logic b;
    s = h;
    for (int k = 0; k < 32; k++) begin
      if (k < n) begin
        b = s[13] ^ s[14];
        s = {s[13:0], b};
      end
    end
    return s;
  endfunction

  function automatic int unsigned pop32(logic [31:0] v);
    int unsigned c;
    c = 0;
    for (int k = 0; k < 32; k++) c += 32'(v[k]);
    return c;
  endfunction

endpackage

// File: rtl/lst_pattern_gen.sv
module lst_pattern_gen
  import lst_pkg::*;
#(
  parameter int          WORD_W    = 10,
  parameter int          RUN_WORDS = 2_200_000,
  parameter prbs_state_t SEED      = 15'h4A5D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);

  localparam int CNT_W = $clog2(RUN_WORDS + 1);

  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  prbs_state_t       state_q;
  logic [31:0]       bits_full;
  prbs_state_t       state_nxt;

  always_comb begin
    bits_full = prbs_bits(state_q, WORD_W);
    state_nxt = prbs_after(state_q, WORD_W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      state_q  <= SEED;
      word_o   <= '0;
      valid_o  <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      state_q  <= SEED;
      valid_o  <= 1'b0;
    end else if (active_q) begin
      word_o  <= bits_full[WORD_W-1:0];
      valid_o <= 1'b1;
      state_q <= state_nxt;
      cnt_q   <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(RUN_WORDS - 1)) active_q <= 1'b0;
    end else begin
      valid_o <= 1'b0;
    end
  end

endmodule

// File: rtl/lst_err_accum.sv
module lst_err_accum #(
  parameter int ADD_W = 4,
  parameter int LIMIT = 220
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             add_en_i,
  input  logic [ADD_W-1:0] add_i,
  output logic             over_next_o
);

  // Counting stops one above the limit: only "above or not" matters.
  localparam int SAT  = LIMIT + 1;
  localparam int CW   = $clog2(SAT + 1);
  localparam int SUMW = ((CW > ADD_W) ? CW : ADD_W) + 1;

  logic [CW-1:0]   cnt_q, cnt_d;
  logic [SUMW-1:0] sum;

  always_comb begin
    sum   = SUMW'(cnt_q) + SUMW'(add_i);
    cnt_d = cnt_q;
    if (clear_i)       cnt_d = '0;
    else if (add_en_i) cnt_d = (sum > SUMW'(SAT)) ? CW'(SAT) : CW'(sum);
    over_next_o = cnt_d > CW'(LIMIT);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

endmodule

// File: rtl/link_selftest.sv
module link_selftest
  import lst_pkg::*;
#(
  parameter int          WORD_W    = 10,
  parameter int          RUN_WORDS = 2_200_000,
  parameter int          BER_DEN   = 10_000_000,
  parameter int          START_WIN = 4096,
  parameter prbs_state_t TX_SEED   = 15'h4A5D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_start_i,
  output logic [WORD_W-1:0] tx_word_o,
  output logic              tx_valid_o,
  input  logic              arm_i,
  input  logic [WORD_W-1:0] rx_word_i,
  input  logic              rx_valid_i,
  output logic              done_o,
  output logic              pass_o
);

  localparam int THRESH = (RUN_WORDS * WORD_W) / BER_DEN;
  localparam int CNT_W  = $clog2(RUN_WORDS + 1);
  localparam int WIN_W  = $clog2(START_WIN);
  localparam int ADD_W  = $clog2(WORD_W + 1);

  lst_pattern_gen #(
    .WORD_W(WORD_W), .RUN_WORDS(RUN_WORDS), .SEED(TX_SEED)
  ) u_gen (
    .clk(clk), .rst(rst), .start_i(tx_start_i),
    .word_o(tx_word_o), .valid_o(tx_valid_o)
  );

  chk_state_t          st_q;
  logic [WIN_W-1:0]    win_q;
  logic [CNT_W-1:0]    wcnt_q;
  logic [WORD_W-1:0]   first_q;
  prbs_state_t         hist_q;

  logic [31:0]         exp_full;
  logic [WORD_W-1:0]   exp_w;
  logic [WORD_W-1:0]   rx_m;
  logic [2*WORD_W-1:0] two_words;
  prbs_state_t         hist_adv, hist_seed;
  logic                seeding, last_word, add_en, over_next;
  logic [ADD_W-1:0]    add_val;

  always_comb begin
    exp_full  = prbs_bits(hist_q, WORD_W);
    exp_w     = exp_full[WORD_W-1:0];
    hist_adv  = prbs_after(hist_q, WORD_W);
    rx_m      = rx_valid_i ? rx_word_i : '0;
    two_words = {rx_m, first_q};
    for (int j = 0; j < PRBS_LEN; j++) hist_seed[j] = two_words[2*WORD_W-1-j];
    seeding   = (wcnt_q == CNT_W'(1));
    last_word = (wcnt_q == CNT_W'(RUN_WORDS - 1));
    add_en    = (st_q == S_RUN) && !arm_i;
    if (!rx_valid_i) add_val = ADD_W'(WORD_W);
    else if (seeding) add_val = '0;
    else add_val = ADD_W'(pop32(32'(exp_w ^ rx_word_i)));
  end

  lst_err_accum #(.ADD_W(ADD_W), .LIMIT(THRESH)) u_acc (
    .clk(clk), .rst(rst), .clear_i(arm_i), .add_en_i(add_en),
    .add_i(add_val), .over_next_o(over_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_IDLE;
      win_q   <= '0;
      wcnt_q  <= '0;
      first_q <= '0;
      hist_q  <= '0;
      done_o  <= 1'b0;
      pass_o  <= 1'b0;
    end else if (arm_i) begin
      st_q   <= S_WAIT;
      win_q  <= '0;
      done_o <= 1'b0;
      pass_o <= 1'b0;
    end else begin
      case (st_q)
        S_WAIT: begin
          if (rx_valid_i) begin
            st_q    <= S_RUN;
            wcnt_q  <= CNT_W'(1);
            first_q <= rx_word_i;
          end else if (win_q == WIN_W'(START_WIN - 1)) begin
            st_q   <= S_IDLE;
            done_o <= 1'b1;
            pass_o <= 1'b0;
          end else begin
            win_q <= win_q + 1'b1;
          end
        end
        S_RUN: begin
          wcnt_q <= wcnt_q + 1'b1;
          hist_q <= seeding ? hist_seed : hist_adv;
          if (last_word) begin
            st_q   <= S_IDLE;
            done_o <= 1'b1;
            pass_o <= !over_next;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/lst_sva.sv
module lst_sva (
  input logic clk,
  input logic rst,
  input logic arm_i,
  input logic tx_start_i,
  input logic tx_valid_o,
  input logic done_o,
  input logic pass_o
);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!done_o && !pass_o && !tx_valid_o));

  assert_start_gap_R2: assert property (@(posedge clk) disable iff (rst)
    tx_start_i |=> !tx_valid_o);

  assert_stream_begins_R2: assert property (@(posedge clk) disable iff (rst)
    (!tx_start_i && $past(tx_start_i)) |=> tx_valid_o);

  assert_arm_clears_R3: assert property (@(posedge clk) disable iff (rst)
    arm_i |=> (!done_o && !pass_o));

  assert_pass_needs_done_R9: assert property (@(posedge clk) disable iff (rst)
    pass_o |-> done_o);

  assert_status_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (done_o && !arm_i) |=> (done_o && $stable(pass_o)));

endmodule

bind link_selftest lst_sva u_sva (
  .clk(clk), .rst(rst), .arm_i(arm_i), .tx_start_i(tx_start_i),
  .tx_valid_o(tx_valid_o), .done_o(done_o), .pass_o(pass_o)
);

// File: tb/sim_link_selftest.sv
module sim_link_selftest;

  localparam int W   = 10;
  localparam int RW  = 400;
  localparam int BD  = 1000;
  localparam int SW  = 16;
  localparam int THR = (RW * W) / BD;
  localparam int DLY = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tx_start_i = 1'b0;
  logic [W-1:0] tx_word_o;
  logic         tx_valid_o;
  logic         arm_i = 1'b0;
  logic [W-1:0] rx_word_i = '0;
  logic         rx_valid_i = 1'b0;
  logic         done_o, pass_o;

  int checks = 0;
  int fails  = 0;

  link_selftest #(.WORD_W(W), .RUN_WORDS(RW), .BER_DEN(BD), .START_WIN(SW)) u0 (
    .clk(clk), .rst(rst), .tx_start_i(tx_start_i), .tx_word_o(tx_word_o),
    .tx_valid_o(tx_valid_o), .arm_i(arm_i), .rx_word_i(rx_word_i),
    .rx_valid_i(rx_valid_i), .done_o(done_o), .pass_o(pass_o)
  );

  always #10 clk = ~clk;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Scenario-driven corruption of the looped-back stream, by word index.
  int cur_scen = 0;
  function automatic logic [W-1:0] fmask(int n);
    case (cur_scen)
      1: return (n == 3 || n == 50 || n == 200 || n == 400) ? W'(1 << (n % W)) : '0;
      2: return (n == 3 || n == 50 || n == 200) ? W'(4) : (n == 400) ? W'(10'h300) : '0;
      3: return (n == 1) ? W'(10'h01F) : '0;
      default: return '0;
    endcase
  endfunction
  function automatic bit fdrop(int n);
    return (cur_scen == 4) && (n == 30);
  endfunction

  // Behavioural reference model, one step per clock edge.
  int mst = 0, mwin = 0, mw = 0, me = 0;
  bit mdone = 0, mpass = 0;
  int txn = 0, rx_n = 0;
  bit gbits[$];

  always @(posedge clk) begin
    if (tx_start_i) begin txn = 0; gbits.delete(); end
    if (rst) begin
      mst = 0; mdone = 0; mpass = 0;
    end else if (arm_i) begin
      mst = 1; mwin = 0; mdone = 0; mpass = 0;
    end else if (mst == 1) begin
      if (rx_valid_i) begin mst = 2; mw = 1; me = 0; end
      else begin
        mwin++;
        if (mwin == SW) begin mst = 0; mdone = 1; mpass = 0; end
      end
    end else if (mst == 2) begin
      mw++;
      if (!rx_valid_i) me += W;
      else if (mw >= 3) me += $countones(fmask(rx_n));
      if (mw == RW) begin mst = 0; mdone = 1; mpass = (me <= THR); end
    end
  end

  // Compare on every clock, check the generator stream, drive the loopback.
  logic [W-1:0] dq_w[$];
  bit           dq_v[$];
  int           dq_n[$];

  always @(negedge clk) begin
    if (!rst) begin
      chk(done_o === mdone, "R5", "done_o vs model", done_o, mdone);
      chk(pass_o === mpass, "R7", "pass_o vs model", pass_o, mpass);
    end
    if (tx_valid_o) begin
      txn++;
      for (int k = 0; k < W; k++) begin
        gbits.push_back(tx_word_o[k]);
        if (gbits.size() > 15) begin
          int n = gbits.size() - 1;
          chk(gbits[n] == (gbits[n-14] ^ gbits[n-15]), "R2", "prbs recurrence",
              gbits[n], gbits[n-14] ^ gbits[n-15]);
        end
      end
    end
    dq_w.push_back(tx_word_o);
    dq_v.push_back(tx_valid_o);
    dq_n.push_back(txn);
    if (dq_w.size() > DLY) begin
      logic [W-1:0] w;
      bit v;
      int n;
      w = dq_w.pop_front(); v = dq_v.pop_front(); n = dq_n.pop_front();
      rx_n       <= n;
      rx_word_i  <= w ^ fmask(n);
      rx_valid_i <= v && !fdrop(n);
    end else begin
      rx_valid_i <= 1'b0;
    end
  end

  // gap < 0: no transmit start. rearm > 0: re-arm that many cycles later.
  task automatic run_test(int scen, int gap, int rearm, bit exp_pass, string req);
    bit held;
    cur_scen = scen;
    @(negedge clk);
    arm_i = 1'b1;
    if (gap == 0) tx_start_i = 1'b1;
    @(negedge clk);
    arm_i = 1'b0;
    tx_start_i = 1'b0;
    chk(!done_o && !pass_o, "R3", "status cleared after arm", {done_o, pass_o}, 0);
    if (gap > 0) begin
      repeat (gap - 1) @(negedge clk);
      tx_start_i = 1'b1;
      @(negedge clk);
      tx_start_i = 1'b0;
    end
    if (rearm > 0) begin
      repeat (rearm) @(negedge clk);
      arm_i = 1'b1;
      @(negedge clk);
      arm_i = 1'b0;
    end
    for (int i = 0; i < 3000 && !done_o; i++) @(negedge clk);
    chk(done_o === 1'b1, req, "done at end of test", done_o, 1);
    chk(pass_o === exp_pass, req, "pass result", pass_o, exp_pass);
    held = pass_o;
    repeat (20) @(negedge clk);
    chk(done_o === 1'b1 && pass_o === held, "R9", "status held", {done_o, pass_o}, {1'b1, held});
    while (tx_valid_o) @(negedge clk);
    repeat (DLY + 3) @(negedge clk);
    if (gap >= 0) chk(txn == RW, "R2", "words in stream", txn, RW);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done_o && !pass_o && !tx_valid_o, "R1", "reset state",
        {done_o, pass_o, tx_valid_o}, 0);
    run_test(0, 0, 0, 1'b1, "R5");   // clean loop with latency: R10
    run_test(1, 0, 0, 1'b1, "R7");   // errors equal to threshold, incl. word 3 and last
    run_test(2, 0, 0, 1'b0, "R7");   // one above threshold
    run_test(3, 0, 0, 1'b1, "R6");   // unseeded bits of word 1 ignored
    run_test(4, 0, 0, 1'b0, "R8");   // one dropped word
    run_test(0, -1, 0, 1'b0, "R4");  // nothing arrives: window timeout
    run_test(0, 12, 0, 1'b1, "R4");  // first word on the last window edge
    run_test(0, 13, 0, 1'b0, "R4");  // one edge too late
    run_test(0, 0, 100, 1'b0, "R3"); // re-arm mid-run restarts on stream tail
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule